// File: doc/BRIEF.md
# Masked SIMD Lane Writeback Unit

This unit sits between the operand network and the per-lane arithmetic units of a 512-bit vector pipe built from sixteen 32-bit lanes. For each operation it prepares the second operand seen by every lane, either that lane's own slice or one 32-bit scalar copied to all lanes. It also selects the 2-bit rounding mode given to the lanes. Both outputs are combinational, so the lanes see them in the same cycle as the operands.

When the lane results come back, the unit merges them into a 512-bit destination register. A per-lane predicate decides which lanes take a result. A lane whose predicate bit is clear either keeps its old contents or is zeroed. The bits above the active vector length are zeroed or kept depending on the encoding class of the operation. In the legacy class the destination register also serves as the first source, so the bits it holds above 128 survive the write.

The class input uses three codes. 0 is the legacy 128-bit class. 1 is the plain vector class, and code 3 behaves the same way. 2 is the mask-capable class.

Top module: `lane_wb_top`

## Requirements
- R1: The vector-length code sets the number of active lanes: 0 gives 4 lanes (128 bits) and 1 gives 8 lanes (256 bits). Codes 2 and 3 give 16 lanes (512 bits). Lane j occupies bits [32j+31:32j], and predicate bit j governs it.
- R2: In classes 0, 1 and 3 the predicate input is ignored, and every active lane takes its result on a valid write.
- R3: In class 2 with merge mode (zero_mode_i = 0), an active lane whose predicate bit is 0 keeps its previous destination value.
- R4: In class 2 with zeroing mode (zero_mode_i = 1), an active lane whose predicate bit is 0 is written with 0.
- R5: In class 2 with bcast_i = 1 and src2_mem_i = 1, every lane of op2_o equals src2_i[31:0]. In every other case, lane j of op2_o equals lane j of src2_i.
- R6: In classes 1, 2 and 3, a valid write clears all destination bits above the active vector length.
- R7: In class 0, the vector length is always 128 bits, whatever vl_i says, and a valid write leaves destination bits [511:128] unchanged.
- R8: rmode_o equals rc_embed_i only when the class is 2, the vector length is 512, bcast_i = 1 and src2_mem_i = 0. Otherwise it equals rc_global_i. The encoding is 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity and 11 toward zero.
- R9: While rst_n is low, the whole destination reads 0.
- R10: The destination changes only on a clock edge where valid_i is 1. The new value is visible after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Single-cycle write strobe |
| cls_i | input | 2 | Encoding class |
| vl_i | input | 2 | Vector-length code |
| mask_i | input | 16 | Per-lane predicate |
| zero_mode_i | input | 1 | 1 = zeroing, 0 = merging |
| bcast_i | input | 1 | Broadcast request |
| src2_mem_i | input | 1 | Second operand comes from memory |
| rc_embed_i | input | 2 | Rounding mode embedded in the operation |
| rc_global_i | input | 2 | Rounding field of the global control register |
| src2_i | input | 512 | Second operand vector |
| lane_res_i | input | 512 | Per-lane results from the lane units |
| op2_o | output | 512 | Second operand presented to the lanes |
| rmode_o | output | 2 | Rounding mode presented to the lanes |
| dst_o | output | 512 | Destination register |

## Verification
The operand and rounding outputs are combinational. The bench samples them 1 time unit after driving the inputs, which is in the same cycle and before the next rising edge. The destination passes through one register, so the bench compares it 1 time unit after the next rising edge. At that point the reference model has applied exactly one update, or none when valid is low. Every step compares all three results against the behavioural model. The directed steps come first, followed by a mixed random phase.

// File: rtl/lane_wb_pkg.sv
package lane_wb_pkg;
    typedef enum logic [1:0] {
        CLS_LEGACY = 2'd0,
        CLS_VEC    = 2'd1,
        CLS_MASKED = 2'd2,
        CLS_VEC_B  = 2'd3
    } enc_cls_e;

    typedef enum logic [1:0] {
        RM_NEAR = 2'd0,
        RM_DOWN = 2'd1,
        RM_UP   = 2'd2,
        RM_ZERO = 2'd3
    } rmode_e;
endpackage

// File: rtl/lane_wb_opsel.sv
module lane_wb_opsel #(
    parameter int LANES = 16,
    parameter int LW    = 32
) (
    input  logic                bcast_en,
    input  logic [LANES*LW-1:0] src2,
    output logic [LANES*LW-1:0] op2
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign op2[g*LW +: LW] = bcast_en ? src2[LW-1:0] : src2[g*LW +: LW];
    end
endmodule

// File: rtl/lane_wb_rsel.sv
module lane_wb_rsel (
    input  logic       masked_cls,
    input  logic       full_len,
    input  logic       bcast,
    input  logic       from_mem,
    input  logic [1:0] rc_embed,
    input  logic [1:0] rc_global,
    output logic [1:0] rmode
);
    logic use_embed;
    always_comb begin
        use_embed = masked_cls & full_len & bcast & ~from_mem;
        rmode     = use_embed ? rc_embed : rc_global;
    end
endmodule

// File: rtl/lane_wb_merge.sv
module lane_wb_merge #(
    parameter int LANES = 16,
    parameter int LW    = 32
) (
    input  logic                masked_cls,
    input  logic                legacy_cls,
    input  logic                zero_mode,
    input  logic [1:0]          vl,
    input  logic [LANES-1:0]    mask,
    input  logic [LANES*LW-1:0] res,
    input  logic [LANES*LW-1:0] old,
    output logic [LANES*LW-1:0] nxt
);
    logic [LANES-1:0] act;
    logic [LANES-1:0] en;

    always_comb begin
        for (int j = 0; j < LANES; j++) begin
            if (legacy_cls || vl == 2'd0) act[j] = (j < 4);
            else if (vl == 2'd1)          act[j] = (j < 8);
            else                          act[j] = 1'b1;
            en[j] = ~masked_cls | mask[j];
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            if (act[g]) begin
                if (en[g])          nxt[g*LW +: LW] = res[g*LW +: LW];
                else if (zero_mode) nxt[g*LW +: LW] = '0;
                else                nxt[g*LW +: LW] = old[g*LW +: LW];
            end else begin
                nxt[g*LW +: LW] = legacy_cls ? old[g*LW +: LW] : '0;
            end
        end
    end
endmodule

// File: rtl/lane_wb_top.sv
module lane_wb_top
    import lane_wb_pkg::*;
#(
    parameter int LANES = 16,
    parameter int LW    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid_i,
    input  logic [1:0]          cls_i,
    input  logic [1:0]          vl_i,
    input  logic [LANES-1:0]    mask_i,
    input  logic                zero_mode_i,
    input  logic                bcast_i,
    input  logic                src2_mem_i,
    input  logic [1:0]          rc_embed_i,
    input  logic [1:0]          rc_global_i,
    input  logic [LANES*LW-1:0] src2_i,
    input  logic [LANES*LW-1:0] lane_res_i,
    output logic [LANES*LW-1:0] op2_o,
    output logic [1:0]          rmode_o,
    output logic [LANES*LW-1:0] dst_o
);
    localparam int VW  = LANES * LW;
    localparam int LOW = 4 * LW;

    typedef struct packed {
        logic [VW-1:0] dst;
    } wb_state_t;

    wb_state_t     st_d, st_q;
    logic          masked_cls, legacy_cls;
    logic [VW-1:0] merged;

    assign masked_cls = (cls_i == CLS_MASKED);
    assign legacy_cls = (cls_i == CLS_LEGACY);

    lane_wb_opsel #(.LANES(LANES), .LW(LW)) u_opsel (
        .bcast_en (masked_cls & bcast_i & src2_mem_i),
        .src2     (src2_i),
        .op2      (op2_o)
    );

    lane_wb_rsel u_rsel (
        .masked_cls (masked_cls),
        .full_len   (vl_i[1]),
        .bcast      (bcast_i),
        .from_mem   (src2_mem_i),
        .rc_embed   (rc_embed_i),
        .rc_global  (rc_global_i),
        .rmode      (rmode_o)
    );

    lane_wb_merge #(.LANES(LANES), .LW(LW)) u_merge (
        .masked_cls (masked_cls),
        .legacy_cls (legacy_cls),
        .zero_mode  (zero_mode_i),
        .vl         (vl_i),
        .mask       (mask_i),
        .res        (lane_res_i),
        .old        (st_q.dst),
        .nxt        (merged)
    );

    always_comb begin
        st_d = st_q;
        if (valid_i) st_d.dst = merged;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dst_o = st_q.dst;

    // Zeroing masking clears a disabled lane 0.
    assert_zero_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && masked_cls && zero_mode_i && !mask_i[0]) |=> (dst_o[LW-1:0] == '0));

    // Merge masking keeps a disabled lane 1.
    assert_merge_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && masked_cls && !zero_mode_i && !mask_i[1])
        |=> (dst_o[2*LW-1:LW] == $past(dst_o[2*LW-1:LW])));

    // The legacy class keeps the upper bits.
    assert_legacy_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && legacy_cls) |=> (dst_o[VW-1:LOW] == $past(dst_o[VW-1:LOW])));

    // A 128-bit write in the other classes clears the upper bits.
    assert_clear_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !legacy_cls && vl_i == 2'd0) |=> (dst_o[VW-1:LOW] == '0));

    // The destination holds when no write is strobed.
    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(dst_o));

    // Without broadcast the global rounding field is used.
    assert_rmode_global_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bcast_i |-> (rmode_o == rc_global_i));

    // A broadcast from memory copies the scalar into the top lane.
    assert_bcast_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (masked_cls && bcast_i && src2_mem_i) |-> (op2_o[VW-1:VW-LW] == src2_i[LW-1:0]));
endmodule

// File: tb/lane_wb_top_tb.sv
module lane_wb_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int L  = 16;
    localparam int W  = 32;
    localparam int VW = L * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          valid_i = 1'b0;
    logic [1:0]    cls_i = '0, vl_i = '0, rc_embed_i = '0, rc_global_i = '0;
    logic [L-1:0]  mask_i = '0;
    logic          zero_mode_i = 1'b0, bcast_i = 1'b0, src2_mem_i = 1'b0;
    logic [VW-1:0] src2_i = '0, lane_res_i = '0;
    logic [VW-1:0] op2_o, dst_o;
    logic [1:0]    rmode_o;

    int            checks = 0;
    int            fails = 0;
    logic [VW-1:0] model = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_wb_top u_dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .cls_i(cls_i), .vl_i(vl_i),
        .mask_i(mask_i), .zero_mode_i(zero_mode_i), .bcast_i(bcast_i),
        .src2_mem_i(src2_mem_i), .rc_embed_i(rc_embed_i), .rc_global_i(rc_global_i),
        .src2_i(src2_i), .lane_res_i(lane_res_i), .op2_o(op2_o), .rmode_o(rmode_o),
        .dst_o(dst_o)
    );

    task automatic chk(string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [VW-1:0] rnd_vec();
        logic [VW-1:0] v;
        for (int k = 0; k < L; k++) v[k*W +: W] = $urandom;
        return v;
    endfunction

    task automatic step(string tag, logic v, logic [1:0] c, logic [1:0] len,
                        logic [L-1:0] m, logic z, logic b, logic mem,
                        logic [1:0] re, logic [1:0] rg);
        logic [VW-1:0] e_op, e_dst;
        logic [1:0]    e_rm;
        int            nl;
        @(negedge clk);
        valid_i = v; cls_i = c; vl_i = len; mask_i = m; zero_mode_i = z;
        bcast_i = b; src2_mem_i = mem; rc_embed_i = re; rc_global_i = rg;
        src2_i = rnd_vec(); lane_res_i = rnd_vec();
        #1;
        for (int j = 0; j < L; j++)
            e_op[j*W +: W] = (c == 2 && b && mem) ? src2_i[W-1:0] : src2_i[j*W +: W];
        e_rm = (c == 2 && len >= 2 && b && !mem) ? re : rg;
        chk({tag, " op2"}, op2_o, e_op);
        chk({tag, " rmode"}, {{(VW-2){1'b0}}, rmode_o}, {{(VW-2){1'b0}}, e_rm});
        nl = (c == 0 || len == 0) ? 4 : (len == 1) ? 8 : 16;
        e_dst = model;
        if (v) begin
            for (int j = 0; j < L; j++) begin
                if (j < nl) begin
                    if (c != 2 || m[j]) e_dst[j*W +: W] = lane_res_i[j*W +: W];
                    else if (z)         e_dst[j*W +: W] = '0;
                end else if (c != 0) begin
                    e_dst[j*W +: W] = '0;
                end
            end
        end
        @(posedge clk);
        #1;
        model = e_dst;
        chk({tag, " dst"}, dst_o, e_dst);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R9 reset", dst_o, '0);
        @(negedge clk);
        rst_n = 1'b1;
        step("R2 mask ignored vec", 1, 1, 2, 16'h0000, 0, 0, 0, 0, 0);
        step("R2 mask ignored vec3", 1, 3, 2, 16'h1234, 1, 0, 0, 0, 0);
        step("R3 merge", 1, 2, 2, 16'h00F5, 0, 0, 0, 0, 0);
        step("R4 zeroing", 1, 2, 2, 16'h0F0F, 1, 0, 0, 0, 0);
        step("R1 full masked", 1, 2, 3, 16'hFFFF, 0, 0, 0, 0, 0);
        step("R6 masked 128", 1, 2, 0, 16'hFFFF, 0, 0, 0, 0, 0);
        step("R1 fill", 1, 1, 2, 16'h0, 0, 0, 0, 0, 0);
        step("R6 vec 256", 1, 1, 1, 16'h0, 0, 0, 0, 0, 0);
        step("R1 fill2", 1, 1, 2, 16'h0, 0, 0, 0, 0, 0);
        step("R7 legacy keeps upper", 1, 0, 2, 16'h0, 1, 0, 0, 0, 0);
        step("R7 legacy vl ignored", 1, 0, 1, 16'h0003, 1, 1, 1, 0, 0);
        step("R5 broadcast", 1, 2, 2, 16'hFFFF, 0, 1, 1, 2, 1);
        step("R5 no bcast vec class", 1, 1, 2, 16'hFFFF, 0, 1, 1, 2, 1);
        step("R8 embed override", 1, 2, 2, 16'hFFFF, 0, 1, 0, 3, 1);
        step("R8 short length", 1, 2, 1, 16'hFFFF, 0, 1, 0, 3, 1);
        step("R8 memory source", 1, 2, 2, 16'hFFFF, 0, 1, 1, 3, 1);
        step("R8 not masked class", 1, 1, 2, 16'hFFFF, 0, 1, 0, 3, 2);
        step("R10 idle hold", 0, 1, 2, 16'h0, 1, 0, 0, 0, 0);
        step("R10 idle hold2", 0, 2, 0, 16'h0, 1, 0, 0, 0, 0);
        for (int i = 0; i < 400; i++)
            step("R1 random", 1'($urandom), 2'($urandom), 2'($urandom), 16'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom), 2'($urandom));
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule